// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Sequencer

This block works beside a small 8-bit core and takes full charge of interrupt entry and exit. It keeps the interrupt mask (register 5) and the interrupt status (register 6). A free-running timer sets status bit 0 at a fixed period. Status bit n stands for interrupt n. Whenever the core reaches an instruction boundary, the sequencer compares mask and status. If a request is pending and no handler is active, it stalls the core and saves the context on the stack. It then fetches the handler address from a vector table in memory and loads it into the PC.

When the core executes the interrupt-return instruction, the sequencer stalls the core again and restores the context in the reverse order. During both sequences the sequencer drives the stack memory port and the core's register-file, flags, PC and stack-pointer write ports. It performs one memory access per cycle. Ordinary instruction decoding stays in the core.

Top module: `irq_sequencer`

## Requirements
- R1: A dispatch starts only in a cycle where `boundary_i` is high, `iret_i` is low, no handler is active, and (mask AND status) is non-zero. `busy_o` is high in that same cycle. In every other case a boundary leaves `busy_o` low.
- R2: Among the pending bits, the lowest-numbered one wins. The handler address is read from memory address VEC_BASE + n (default 0xF8 + n) and written to the PC on the last dispatch cycle.
- R3: The dispatch cycle clears the whole status register, including any lower-priority pending bits.
- R4: The save pushes PC, then flags, then R0, R1, R2, R3, R4, R5 (mask), R6 (status after clearing), one byte per cycle. Each push writes at the current stack pointer and then decrements it. R7 is not saved. The new stack pointer (start minus 9) is written back on the vector cycle.
- R5: A one-cycle `iret_i` pops nine bytes. Each pop increments the stack pointer and then reads. The bytes go to R6 (status), R5 (mask), R4, R3, R2, R1, R0, the flags and the PC, in that order. The stack pointer plus 9 is written back with the PC.
- R6: The timer sets status bit 0 once every TICK_CYCLES clock cycles. A timer tick takes precedence over any clear or write of that bit in the same cycle.
- R7: From the dispatch until the last restore cycle, boundaries cause no new dispatch.
- R8: `busy_o` stays high for exactly 11 cycles on a dispatch and 10 cycles on a return. Every memory, PC, flags and register write happens only while `busy_o` is high, and at most one of memory, flags and register is written per cycle.
- R9: The core writes the mask with `mask_we_i` and the status with `status_we_i`, using the data on `cfg_wdata_i`. The new value appears on `mask_o` / `status_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary, before fetch |
| iret_i | input | 1 | Core executed the interrupt-return instruction |
| busy_o | output | 1 | Stall the core |
| mask_we_i | input | 1 | Write the mask register |
| status_we_i | input | 1 | Write the status register |
| cfg_wdata_i | input | W | Data for mask/status writes |
| mask_o | output | W | Mask register (R5) value |
| status_o | output | W | Status register (R6) value |
| rf_idx_o | output | 3 | Register-file index for save reads and restore writes |
| rf_rdata_i | input | W | Register-file read data |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | W | Register-file write data |
| pc_i | input | W | Current PC |
| fl_i | input | W | Current flags |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | W | New PC |
| fl_we_o | output | 1 | Flags write strobe |
| fl_o | output | W | New flags |
| sp_i | input | W | Current stack pointer (R7) |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | W | New stack pointer |
| mem_addr_o | output | W | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | W | Memory write data |
| mem_rdata_i | input | W | Memory read data, same cycle |

## Verification
A dispatch raises `busy_o` combinationally in the boundary cycle itself. The nine pushes follow on the next nine cycles, and the PC and stack-pointer writes arrive on the eleventh. A return raises `busy_o` in the `iret_i` cycle and delivers its nine pops over the following nine cycles. Mask and status writes show one edge later, and timer ticks are measured edge to edge. The bench drives inputs just after a rising edge and samples every strobe on the falling edge. A scoreboard compares each strobe against its expected entry in order, so an event that comes one cycle early or late fails the match.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int W = 8,
  parameter int TICK_CYCLES = 1000,
  parameter logic [W-1:0] VEC_BASE = W'('hF8)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boundary_i,
  input  logic         iret_i,
  output logic         busy_o,
  input  logic         mask_we_i,
  input  logic         status_we_i,
  input  logic [W-1:0] cfg_wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] status_o,
  output logic [2:0]   rf_idx_o,
  input  logic [W-1:0] rf_rdata_i,
  output logic         rf_we_o,
  output logic [W-1:0] rf_wdata_o,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] fl_i,
  output logic         pc_we_o,
  output logic [W-1:0] pc_o,
  output logic         fl_we_o,
  output logic [W-1:0] fl_o,
  input  logic [W-1:0] sp_i,
  output logic         sp_we_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i
);
  localparam int NIW = $clog2(W);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam logic [3:0] LAST = 4'd8;

  typedef enum logic [1:0] {IDLE, SAVE, VECT, REST} st_t;

  st_t            st_q;
  logic [3:0]     step_q;
  logic [W-1:0]   sp_q, mask_q, stat_q, mask_n, stat_n, pend, push_d;
  logic [NIW-1:0] num_q, num_c;
  logic           nest_q, take, go_ret, tick;
  logic [TW-1:0]  tcnt_q;

  assign pend   = mask_q & stat_q;
  assign tick   = tcnt_q == TW'(TICK_CYCLES - 1);
  assign go_ret = (st_q == IDLE) && iret_i;
  assign take   = (st_q == IDLE) && boundary_i && !iret_i && !nest_q && (|pend);
  assign busy_o = (st_q != IDLE) || take || go_ret;

  always_comb begin
    num_c = '0;
    for (int i = W - 1; i >= 0; i--)
      if (pend[i]) num_c = NIW'(i);
  end

  always_comb begin
    case (step_q)
      4'd0:    push_d = pc_i;
      4'd1:    push_d = fl_i;
      4'd7:    push_d = mask_q;
      4'd8:    push_d = stat_q;
      default: push_d = rf_rdata_i;
    endcase
  end

  always_comb begin
    stat_n = stat_q;
    if (st_q == REST && step_q == 4'd0) stat_n = mem_rdata_i;
    else if (take)                      stat_n = '0;
    else if (status_we_i)               stat_n = cfg_wdata_i;
    stat_n = stat_n | W'(tick);
    mask_n = mask_q;
    if (st_q == REST && step_q == 4'd1) mask_n = mem_rdata_i;
    else if (mask_we_i)                 mask_n = cfg_wdata_i;
  end

  assign mask_o   = mask_q;
  assign status_o = stat_q;

  assign rf_idx_o   = (st_q == REST) ? 3'd6 - step_q[2:0] : step_q[2:0] - 3'd2;
  assign rf_we_o    = (st_q == REST) && step_q >= 4'd2 && step_q <= 4'd6;
  assign rf_wdata_o = mem_rdata_i;
  assign fl_we_o    = (st_q == REST) && step_q == 4'd7;
  assign fl_o       = mem_rdata_i;
  assign pc_we_o    = (st_q == VECT) || (st_q == REST && step_q == LAST);
  assign pc_o       = mem_rdata_i;
  assign sp_we_o    = pc_we_o;
  assign sp_o       = (st_q == VECT) ? sp_q : sp_q + W'(1);

  assign mem_we_o    = st_q == SAVE;
  assign mem_wdata_o = push_d;
  assign mem_addr_o  = (st_q == VECT) ? VEC_BASE + W'(num_q) :
                       (st_q == REST) ? sp_q + W'(1) : sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      step_q <= '0;
      sp_q   <= '0;
      num_q  <= '0;
      nest_q <= 1'b0;
      mask_q <= '0;
      stat_q <= '0;
      tcnt_q <= '0;
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + TW'(1);
      mask_q <= mask_n;
      stat_q <= stat_n;
      case (st_q)
        IDLE: begin
          step_q <= '0;
          sp_q   <= sp_i;
          if (go_ret) st_q <= REST;
          else if (take) begin
            st_q   <= SAVE;
            num_q  <= num_c;
            nest_q <= 1'b1;
          end
        end
        SAVE: begin
          sp_q   <= sp_q - W'(1);
          step_q <= step_q + 4'd1;
          if (step_q == LAST) st_q <= VECT;
        end
        VECT: st_q <= IDLE;
        REST: begin
          sp_q   <= sp_q + W'(1);
          step_q <= step_q + 4'd1;
          if (step_q == LAST) begin
            st_q   <= IDLE;
            nest_q <= 1'b0;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] VEC_BASE = W'('hF8)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_o,
  input logic         mem_we_o,
  input logic [W-1:0] mem_addr_o,
  input logic         pc_we_o,
  input logic         rf_we_o,
  input logic         fl_we_o,
  input logic [W-1:0] status_o,
  input logic         nest_q
);
  assert_push_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) - W'(1));

  assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we_o, rf_we_o, fl_we_o}));

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || pc_we_o || rf_we_o || fl_we_o) |-> busy_o);

  assert_status_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> (status_o >> 1) == '0);

  assert_no_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> !$past(nest_q));

  assert_vector_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_o && $past(mem_we_o)) |-> mem_addr_o >= VEC_BASE);
endmodule

bind irq_sequencer irq_sequencer_chk #(.W(W), .VEC_BASE(VEC_BASE)) chk_i (.*);

// File: tb/irq_sequencer_tb_top.sv
module irq_sequencer_tb_top;
  localparam int TICK = 64;

  logic clk = 0, rst_n = 0;
  logic boundary_i = 0, iret_i = 0, mask_we_i = 0, status_we_i = 0;
  logic [7:0] cfg_wdata_i = 0;
  logic busy_o, rf_we_o, pc_we_o, fl_we_o, sp_we_o, mem_we_o;
  logic [7:0] mask_o, status_o, rf_wdata_o, pc_o, fl_o, sp_o, mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i;
  logic [2:0] rf_idx_o;
  logic [7:0] mem [0:255];
  logic [7:0] bregs [0:7];
  logic [7:0] pc_r, fl_r, sp_r;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  irq_sequencer #(.W(8), .TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .iret_i(iret_i), .busy_o(busy_o),
    .mask_we_i(mask_we_i), .status_we_i(status_we_i), .cfg_wdata_i(cfg_wdata_i),
    .mask_o(mask_o), .status_o(status_o), .rf_idx_o(rf_idx_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .pc_i(pc_r), .fl_i(fl_r),
    .pc_we_o(pc_we_o), .pc_o(pc_o), .fl_we_o(fl_we_o), .fl_o(fl_o),
    .sp_i(sp_r), .sp_we_o(sp_we_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i));

  assign mem_rdata_i = mem[mem_addr_o];
  assign rf_rdata_i  = bregs[rf_idx_o];

  // environment: memory and core register model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pc_r <= 8'h12; fl_r <= 8'h05; sp_r <= 8'hF3;
      bregs[0] <= 8'h11; bregs[1] <= 8'h22; bregs[2] <= 8'h33; bregs[3] <= 8'h44;
      bregs[4] <= 8'h55; bregs[5] <= 8'h00; bregs[6] <= 8'h00; bregs[7] <= 8'h00;
    end else begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      if (pc_we_o)  pc_r <= pc_o;
      if (fl_we_o)  fl_r <= fl_o;
      if (sp_we_o)  sp_r <= sp_o;
      if (rf_we_o)  bregs[rf_idx_o] <= rf_wdata_o;
    end
  end

  // scoreboard: kind 0 mem, 1 pc, 2 flags, 3 regfile, 4 sp
  typedef struct packed { logic [2:0] k; logic [7:0] a; logic [7:0] d; logic [7:0] c; } ev_t;
  ev_t   exq[$];
  string tgq[$];

  task automatic exp_ev(input logic [2:0] k, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] c, input string tg);
    exq.push_back({k, a, d, c});
    tgq.push_back(tg);
  endtask

  task automatic see(input logic [2:0] k, input logic [7:0] a, input logic [7:0] d);
    ev_t e;
    string t;
    total++;
    if (exq.size() == 0) begin
      bad++;
      $display("FAIL R8 unexpected strobe: actual kind=%0d addr=%h data=%h expected none", k, a, d);
    end else begin
      e = exq.pop_front();
      t = tgq.pop_front();
      if (e.k != k || e.a != a || ((e.d ^ d) & e.c) != 0) begin
        bad++;
        $display("FAIL %s strobe: actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                 t, k, a, d, e.k, e.a, e.d);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we_o) see(3'd0, mem_addr_o, mem_wdata_o);
    if (pc_we_o)  see(3'd1, 8'h00, pc_o);
    if (fl_we_o)  see(3'd2, 8'h00, fl_o);
    if (rf_we_o)  see(3'd3, {5'd0, rf_idx_o}, rf_wdata_o);
    if (sp_we_o)  see(3'd4, 8'h00, sp_o);
  end

  task automatic chk(input string tg, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic edge_drive;
    @(posedge clk); #2;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      @(posedge clk); #2;
      iret_i = 0; boundary_i = 0;
      @(negedge clk);
    end
  endtask

  task automatic exp_save(input logic [7:0] pc, input logic [7:0] r0, input logic [7:0] r5,
                          input logic [7:0] r6c, input logic [7:0] vec);
    exp_ev(0, 8'hF3, pc, 8'hFF, "R4 push PC");
    exp_ev(0, 8'hF2, 8'h05, 8'hFF, "R4 push flags");
    exp_ev(0, 8'hF1, r0, 8'hFF, "R4 push R0");
    exp_ev(0, 8'hF0, 8'h22, 8'hFF, "R4 push R1");
    exp_ev(0, 8'hEF, 8'h33, 8'hFF, "R4 push R2");
    exp_ev(0, 8'hEE, 8'h44, 8'hFF, "R4 push R3");
    exp_ev(0, 8'hED, 8'h55, 8'hFF, "R4 push R4");
    exp_ev(0, 8'hEC, r5, 8'hFF, "R4 push R5 mask");
    exp_ev(0, 8'hEB, 8'h00, r6c, "R3 pushed status cleared");
    exp_ev(1, 8'h00, vec, 8'hFF, "R2 handler PC");
    exp_ev(4, 8'h00, 8'hEA, 8'hFF, "R4 SP writeback");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    int n, c0;
    logic prev;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'hF8] = 8'h30;
    mem[8'hFB] = 8'h40;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R9 reset mask", mask_o, 0);
    chk("R9 reset status", status_o & 8'hFE, 0);

    // R9: mask/status writes, no overlap -> no dispatch (R1)
    edge_drive(); mask_we_i = 1; cfg_wdata_i = 8'h2C;
    edge_drive(); mask_we_i = 0; status_we_i = 1; cfg_wdata_i = 8'h02;
    edge_drive(); status_we_i = 0;
    @(negedge clk);
    chk("R9 mask readback", mask_o, 8'h2C);
    chk("R9 status readback", status_o & 8'hFE, 8'h02);
    edge_drive(); boundary_i = 1;
    @(negedge clk);
    chk("R1 no dispatch when mask AND status is zero", busy_o, 0);
    edge_drive(); boundary_i = 0;

    // R2/R3/R4: status 0x2A & mask 0x2C -> bits 3 and 5 pending, bit 3 wins
    status_we_i = 1; cfg_wdata_i = 8'h2A;
    edge_drive(); status_we_i = 0;
    exp_save(8'h12, 8'h11, 8'h2C, 8'hFE, 8'h40);
    edge_drive(); boundary_i = 1;
    @(negedge clk);
    chk("R1 busy in boundary cycle", busy_o, 1);
    count_busy(n);
    chk("R8 dispatch busy length", n, 11);
    chk("R3 status cleared after dispatch", status_o & 8'hFE, 0);
    chk("R4 all pushes seen", exq.size(), 0);

    // R7: new request inside handler is ignored
    edge_drive(); status_we_i = 1; cfg_wdata_i = 8'h04;
    edge_drive(); status_we_i = 0; boundary_i = 1;
    @(negedge clk);
    chk("R7 no nested dispatch", busy_o, 0);
    edge_drive(); boundary_i = 0;

    // R5: handler edits stack image, then return
    mem[8'hF3] = 8'h77; mem[8'hF1] = 8'h99; mem[8'hEC] = 8'h10; mem[8'hEB] = 8'h40;
    exp_ev(3, 8'h04, 8'h55, 8'hFF, "R5 pop R4");
    exp_ev(3, 8'h03, 8'h44, 8'hFF, "R5 pop R3");
    exp_ev(3, 8'h02, 8'h33, 8'hFF, "R5 pop R2");
    exp_ev(3, 8'h01, 8'h22, 8'hFF, "R5 pop R1");
    exp_ev(3, 8'h00, 8'h99, 8'hFF, "R5 pop R0");
    exp_ev(2, 8'h00, 8'h05, 8'hFF, "R5 pop flags");
    exp_ev(1, 8'h00, 8'h77, 8'hFF, "R5 pop PC");
    exp_ev(4, 8'h00, 8'hF3, 8'hFF, "R5 SP writeback");
    edge_drive(); iret_i = 1;
    @(negedge clk);
    count_busy(n);
    chk("R8 return busy length", n, 10);
    chk("R5 mask restored", mask_o, 8'h10);
    chk("R5 status restored", status_o & 8'hFE, 8'h40);
    chk("R5 all pops seen", exq.size(), 0);

    // R6: timer period and timer-driven dispatch after return (R7 released)
    edge_drive(); status_we_i = 1; cfg_wdata_i = 8'h00;
    edge_drive(); status_we_i = 0;
    @(negedge clk);
    prev = status_o[0];
    for (int i = 0; i < 200 && !(status_o[0] && !prev); i++) begin
      prev = status_o[0];
      @(negedge clk);
    end
    c0 = cyc;
    chk("R6 tick seen", status_o[0], 1);
    edge_drive(); status_we_i = 1; cfg_wdata_i = 8'h00;
    edge_drive(); status_we_i = 0; mask_we_i = 1; cfg_wdata_i = 8'h01;
    edge_drive(); mask_we_i = 0; boundary_i = 1;
    exp_save(8'h77, 8'h99, 8'h01, 8'hFF, 8'h30);
    @(negedge clk);
    for (int i = 0; i < 200 && !busy_o; i++) @(negedge clk);
    chk("R6 timer period", cyc - c0, TICK);
    count_busy(n);
    chk("R8 timer dispatch busy length", n, 11);
    chk("R2 timer vector pushes seen", exq.size(), 0);
    finish_up();
  end
endmodule